// File: doc/BRIEF.md
# Single-Bit-Flip Tag Neighbour Detector

This block looks at one lookup tag against a small array of stored tags. For every entry it reports whether the two tags are equal, and whether they are one bit flip apart. When they are one flip apart, it also gives the index of the bit that differs. Reliability accounting logic uses these results to charge exposure time only to the tag bits that matter under a single-bit upset model.

A stored tag one flip away from the lookup is a hazard. An upset on that bit would turn a correct miss into a wrong hit, so the entry is always flagged as a wrong-hit risk. An entry that matches exactly is a different hazard: an upset in it would turn a hit into a miss. That only corrupts data when the line holds dirty data that must be written back, so the wrong-miss risk is raised only for dirty entries.

All results are registered. They appear one clock after a lookup strobe and are held until the next strobe. The entry count and the tag width are parameters.

Top module: `hd1_tag_match_detector`

## Requirements
- R1: One cycle after a strobe, `exact_hit[i]` is 1 exactly when entry i is valid and its stored tag equals the lookup tag.
- R2: One cycle after a strobe, `near_hit[i]` is 1 exactly when entry i is valid and its stored tag differs from the lookup tag in exactly one bit position.
- R3: `near_pos` holds one unsigned index per entry, with entry i in bits [i*IDX_W +: IDX_W] and IDX_W = ceil(log2(TAG_W)). When `near_hit[i]` is 1, the index names the differing bit, where 0 is the tag's least significant bit. When `near_hit[i]` is 0, the index is 0.
- R4: An entry whose valid bit is 0 raises no exact, near, or risk flag, and its index is 0, even if its stored tag equals the lookup tag.
- R5: `fp_risk[i]` equals `near_hit[i]` for every lookup, whatever the dirty bit says.
- R6: `fn_risk[i]` is 1 exactly when `exact_hit[i]` is 1 and entry i's dirty bit was 1 at the strobe.
- R7: `result_valid` is 1 in exactly the cycle after each cycle in which `lookup_valid` was 1. Cycles without a strobe leave every result output unchanged, even if the tags or flags change.
- R8: While `rst_n` is low, every output is 0.
- R9: No entry raises both `exact_hit` and `near_hit`. Tags two or more bits apart raise neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | Lookup strobe |
| lookup_tag | input | TAG_W | Incoming tag |
| entry_valid | input | N_ENTRIES | Per-entry valid bit |
| entry_dirty | input | N_ENTRIES | Per-entry dirty bit |
| entry_tags | input | N_ENTRIES*TAG_W | Stored tags, entry i at [i*TAG_W +: TAG_W] |
| result_valid | output | 1 | Results updated this cycle |
| exact_hit | output | N_ENTRIES | Equal-tag flags |
| near_hit | output | N_ENTRIES | One-flip-away flags |
| near_pos | output | N_ENTRIES*IDX_W | Differing-bit index per entry |
| fp_risk | output | N_ENTRIES | Wrong-hit risk flags |
| fn_risk | output | N_ENTRIES | Wrong-miss risk flags (dirty exact hits) |

## Verification
Within a single lookup, one entry can be an exact hit while another entry is one flip away. In that same cycle the two different risk flags rise together. The bench builds tag arrays in which some entries copy the lookup tag, some copy it with one bit toggled, some with several bits toggled, and some are marked invalid. Dirty and valid bits are set independently of the tags. A behavioural reference model counts differing bits with an integer loop and checks every flag, index and risk output on every clock. Cycles without a strobe also change the tags, to show that the held results ignore them.

// File: rtl/hd1_pkg.sv
package hd1_pkg;
  // Width of a binary bit index into a tag of the given width.
  function automatic int idx_width(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/hd1_onehot_enc.sv
module hd1_onehot_enc #(
  parameter int W     = 12,
  parameter int IDX_W = 4
) (
  input  logic [W-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);
  // OR together the indices of all set bits; exact for a one-hot input.
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/hd1_entry_cmp.sv
module hd1_entry_cmp #(
  parameter int TAG_W = 12,
  parameter int IDX_W = 4
) (
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic [TAG_W-1:0] stored_tag,
  input  logic             vld,
  input  logic             dirty,
  output logic             exact,
  output logic             near,
  output logic [IDX_W-1:0] pos,
  output logic             fp,
  output logic             fn
);
  logic [TAG_W-1:0] diff;
  logic [TAG_W-1:0] diff_low_cleared;
  logic             nonzero;
  logic             single;
  logic [IDX_W-1:0] enc_idx;

  always_comb begin
    diff             = lookup_tag ^ stored_tag;
    diff_low_cleared = diff & (diff - {{(TAG_W-1){1'b0}}, 1'b1});
    nonzero          = |diff;
    single           = nonzero && (diff_low_cleared == '0);
  end

  hd1_onehot_enc #(.W(TAG_W), .IDX_W(IDX_W)) u_enc (
    .onehot (diff),
    .idx    (enc_idx)
  );

  always_comb begin
    exact = vld & ~nonzero;
    near  = vld & single;
    pos   = near ? enc_idx : '0;
    fp    = near;
    fn    = exact & dirty;
  end
endmodule

// File: rtl/hd1_tag_match_detector.sv
module hd1_tag_match_detector #(
  parameter int N_ENTRIES = 8,
  parameter int TAG_W     = 12,
  localparam int IDX_W    = hd1_pkg::idx_width(TAG_W)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lookup_valid,
  input  logic [TAG_W-1:0]             lookup_tag,
  input  logic [N_ENTRIES-1:0]         entry_valid,
  input  logic [N_ENTRIES-1:0]         entry_dirty,
  input  logic [N_ENTRIES*TAG_W-1:0]   entry_tags,
  output logic                         result_valid,
  output logic [N_ENTRIES-1:0]         exact_hit,
  output logic [N_ENTRIES-1:0]         near_hit,
  output logic [N_ENTRIES*IDX_W-1:0]   near_pos,
  output logic [N_ENTRIES-1:0]         fp_risk,
  output logic [N_ENTRIES-1:0]         fn_risk
);
  logic [N_ENTRIES-1:0]       exact_d, near_d, fp_d, fn_d;
  logic [N_ENTRIES*IDX_W-1:0] pos_d;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    hd1_entry_cmp #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_cmp (
      .lookup_tag (lookup_tag),
      .stored_tag (entry_tags[e*TAG_W +: TAG_W]),
      .vld        (entry_valid[e]),
      .dirty      (entry_dirty[e]),
      .exact      (exact_d[e]),
      .near       (near_d[e]),
      .pos        (pos_d[e*IDX_W +: IDX_W]),
      .fp         (fp_d[e]),
      .fn         (fn_d[e])
    );
  end

  // Next-state: load on strobe, otherwise hold.
  logic                       rv_n;
  logic [N_ENTRIES-1:0]       exact_n, near_n, fp_n, fn_n;
  logic [N_ENTRIES*IDX_W-1:0] pos_n;

  always_comb begin
    rv_n    = lookup_valid;
    exact_n = exact_hit;
    near_n  = near_hit;
    pos_n   = near_pos;
    fp_n    = fp_risk;
    fn_n    = fn_risk;
    if (lookup_valid) begin
      exact_n = exact_d;
      near_n  = near_d;
      pos_n   = pos_d;
      fp_n    = fp_d;
      fn_n    = fn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      exact_hit    <= '0;
      near_hit     <= '0;
      near_pos     <= '0;
      fp_risk      <= '0;
      fn_risk      <= '0;
    end else begin
      result_valid <= rv_n;
      exact_hit    <= exact_n;
      near_hit     <= near_n;
      near_pos     <= pos_n;
      fp_risk      <= fp_n;
      fn_risk      <= fn_n;
    end
  end
endmodule

// File: rtl/hd1_match_checker.sv
module hd1_match_checker #(
  parameter int N_ENTRIES = 8,
  parameter int TAG_W     = 12,
  parameter int IDX_W     = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lookup_valid,
  input logic [N_ENTRIES-1:0]       entry_valid,
  input logic [N_ENTRIES-1:0]       entry_dirty,
  input logic                       result_valid,
  input logic [N_ENTRIES-1:0]       exact_hit,
  input logic [N_ENTRIES-1:0]       near_hit,
  input logic [N_ENTRIES*IDX_W-1:0] near_pos,
  input logic [N_ENTRIES-1:0]       fp_risk,
  input logic [N_ENTRIES-1:0]       fn_risk
);
  // R9
  exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exact_hit & near_hit) == '0);

  // R4
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> ((exact_hit | near_hit | fn_risk) & ~$past(entry_valid)) == '0);

  // R5
  fp_tracks_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_risk == near_hit);

  // R6
  fn_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> fn_risk == (exact_hit & $past(entry_dirty)));

  // R7
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> result_valid);

  // R7
  no_strobe_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !result_valid);

  // R7
  hold_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> ($stable(exact_hit) && $stable(near_hit) && $stable(near_pos)
                       && $stable(fn_risk)));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_pos
    // R3
    pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !near_hit[e] |-> near_pos[e*IDX_W +: IDX_W] == '0);
  end
endmodule

bind hd1_tag_match_detector hd1_match_checker #(
  .N_ENTRIES (N_ENTRIES),
  .TAG_W     (TAG_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookup_valid (lookup_valid),
  .entry_valid  (entry_valid),
  .entry_dirty  (entry_dirty),
  .result_valid (result_valid),
  .exact_hit    (exact_hit),
  .near_hit     (near_hit),
  .near_pos     (near_pos),
  .fp_risk      (fp_risk),
  .fn_risk      (fn_risk)
);

// File: tb/tb_hd1_tag_match_detector.sv
module tb_hd1_tag_match_detector;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int TW = 12;
  localparam int IW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lookup_valid;
  logic [TW-1:0]     lookup_tag;
  logic [N-1:0]      entry_valid, entry_dirty;
  logic [TW-1:0]     tags [N];
  logic [N*TW-1:0]   entry_tags;
  logic              result_valid;
  logic [N-1:0]      exact_hit, near_hit, fp_risk, fn_risk;
  logic [N*IW-1:0]   near_pos;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int e = 0; e < N; e++) entry_tags[e*TW +: TW] = tags[e];
  end

  hd1_tag_match_detector #(.N_ENTRIES(N), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_tag(lookup_tag),
    .entry_valid(entry_valid), .entry_dirty(entry_dirty), .entry_tags(entry_tags),
    .result_valid(result_valid), .exact_hit(exact_hit), .near_hit(near_hit),
    .near_pos(near_pos), .fp_risk(fp_risk), .fn_risk(fn_risk)
  );

  // Behavioural reference model
  logic            m_rv;
  logic [N-1:0]    m_exact, m_near, m_fp, m_fn;
  logic [N*IW-1:0] m_pos;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rv = 0; m_exact = '0; m_near = '0; m_fp = '0; m_fn = '0; m_pos = '0;
    end else begin
      m_rv = lookup_valid;
      if (lookup_valid) begin
        m_exact = '0; m_near = '0; m_fp = '0; m_fn = '0; m_pos = '0;
        for (int e = 0; e < N; e++) begin
          int cnt;
          int where;
          cnt = 0; where = 0;
          for (int b = 0; b < TW; b++) begin
            if (tags[e][b] != lookup_tag[b]) begin
              cnt++;
              where = b;
            end
          end
          if (entry_valid[e]) begin
            if (cnt == 0) begin
              m_exact[e] = 1'b1;
              m_fn[e]    = entry_dirty[e];
            end
            if (cnt == 1) begin
              m_near[e] = 1'b1;
              m_fp[e]   = 1'b1;
              m_pos[e*IW +: IW] = IW'(where);
            end
          end
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) begin
    if (compare_on) begin
      check("R7", "result_valid", 64'(result_valid), 64'(m_rv));
      check("R1 R4 R9", "exact_hit", 64'(exact_hit), 64'(m_exact));
      check("R2 R4 R9", "near_hit", 64'(near_hit), 64'(m_near));
      check("R3", "near_pos", 64'(near_pos), 64'(m_pos));
      check("R5", "fp_risk", 64'(fp_risk), 64'(m_fp));
      check("R6", "fn_risk", 64'(fn_risk), 64'(m_fn));
    end
  end

  task automatic step(input logic strobe);
    lookup_valid = strobe;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; lookup_valid = 0; lookup_tag = '0;
    entry_valid = '1; entry_dirty = '1;
    for (int e = 0; e < N; e++) tags[e] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state with inputs that would otherwise produce hits
    lookup_valid = 1;
    @(negedge clk);
    check("R8", "reset result_valid", 64'(result_valid), 64'd0);
    check("R8", "reset exact_hit", 64'(exact_hit), 64'd0);
    check("R8", "reset near/pos/risk", 64'({near_hit, near_pos, fp_risk, fn_risk}), 64'd0);
    lookup_valid = 0;
    rst_n = 1;
    compare_on = 1;
    @(negedge clk);

    // R2 R3: the six-bit example, differing in bit 5; distant pattern
    lookup_tag = 12'h00A;
    tags[0] = 12'h02A; tags[1] = 12'h015;
    tags[2] = 12'h00A; tags[3] = 12'h00A; tags[4] = 12'h00A;
    tags[5] = 12'h00B; tags[6] = 12'h80A; tags[7] = 12'h009;
    entry_valid = 8'b1110_1111;           // entry 4 invalid despite equal tag (R4)
    entry_dirty = 8'b0000_0100;           // entry 2 dirty, entry 3 clean (R6)
    step(1'b1);
    check("R2", "example near entry0", 64'(near_hit[0]), 64'd1);
    check("R3", "example pos entry0", 64'(near_pos[0 +: IW]), 64'd5);
    check("R9", "distant entry1", 64'({exact_hit[1], near_hit[1]}), 64'd0);
    check("R6", "dirty exact fn", 64'(fn_risk[3:2]), 64'b01);
    check("R4", "invalid equal entry4", 64'({exact_hit[4], fn_risk[4]}), 64'd0);
    check("R3", "pos bit0 and msb", 64'({near_pos[5*IW +: IW], near_pos[6*IW +: IW]}), 64'h0B);
    check("R9", "two-bit diff entry7", 64'({exact_hit[7], near_hit[7]}), 64'd0);

    // R7: no strobe, tags change, results held
    for (int k = 0; k < 3; k++) begin
      tags[0] = 12'h00A; tags[1] = 12'h00B; entry_valid = '0;
      step(1'b0);
    end
    check("R7", "held exact", 64'(exact_hit), 64'h0C);
    entry_valid = '1;

    // Mixed random lookups: copies, single flips, multi flips
    for (int n = 0; n < 400; n++) begin
      lookup_tag = TW'($urandom);
      for (int e = 0; e < N; e++) begin
        int kind;
        kind = $urandom_range(0, 3);
        case (kind)
          0: tags[e] = lookup_tag;
          1: tags[e] = lookup_tag ^ (TW'(1) << $urandom_range(0, TW-1));
          2: tags[e] = lookup_tag ^ TW'(3 << $urandom_range(0, TW-2));
          default: tags[e] = TW'($urandom);
        endcase
      end
      entry_valid = N'($urandom);
      entry_dirty = N'($urandom);
      step(($urandom_range(0, 3) != 0));
    end
    step(1'b0);
    step(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule